// File: doc/BRIEF.md
# Strided Complement-Disturb Memory Test Engine

This block is a built-in self-test controller for a synchronous single-port RAM. It looks for cells that are disturbed when their neighbours are written, and it does this in a way that write buffering cannot hide. The controller picks one cell in every twenty, counted from the low end of the selected address window, and writes it with a test pattern. It then sweeps the whole window again and writes the inverse of the pattern into every other cell. It can repeat this inverse pass several times. Finally it reads back only the chosen cells and compares each one with the pattern. This is done for each of the twenty possible starting offsets, first with an all-zeros pattern and then with an all-ones pattern.

Software or a test sequencer sets the inclusive address window and the number of inverse passes, then pulses `start`. The engine drives the RAM one address per cycle until the run ends. Every failed comparison produces a one-cycle error strobe carrying the failing address, the expected word and the word actually read. When the whole run has finished, `done` goes high and stays high.

Top module: `stride_bist`

## Requirements
- R1: While reset is asserted, `busy`, `done`, `err_valid` and `ram_en` are all low.
- R2: A `start` pulse seen while the engine is idle or done begins a run. The window bounds and the repeat count are sampled on that same edge. While `busy` is high, further `start` pulses and changes to `reps` have no effect on the sequence or on its duration.
- R3: In the stride-write sweep for offset o, each address a in the window is visited once per cycle in ascending order. A write of the pattern word occurs only where (a - addr_lo) mod 20 equals o; every other cycle of the sweep has `ram_en` low. No RAM access occurs while the engine is not busy.
- R4: After the stride-write sweep there are k inverse sweeps, where k is the latched repeat count. Each of them writes the bitwise inverse of the pattern to every address whose (a - addr_lo) mod 20 differs from o, in ascending order, one address per cycle.
- R5: The read sweep that follows issues a read (`ram_en` high, `ram_we` low) only at the addresses of offset o, in ascending order, and compares each word with the pattern.
- R6: A repeat count of 0 behaves exactly like a count of 1.
- R7: Offsets run 0, 1, ..., 19 with the all-zeros pattern, then 0 to 19 again with the all-ones pattern. With window size N and effective repeat count k, `done` first reads high 40*(2+k)*N+1 clock edges after the edge that accepted `start`. No RAM access is made after the last read.
- R8: A read whose data differs from the pattern raises `err_valid` for exactly one cycle, two edges after the edge that sampled the read request. In that cycle `err_addr`, `err_exp` and `err_got` hold the address, the pattern and the returned word. A matching read raises no strobe.
- R9: `done` stays high, with `busy` low, until the next accepted `start`. The strobe for the final read appears in the same cycle in which `done` rises.
- R10: Every RAM access falls inside the inclusive window [addr_lo, addr_hi]. Windows smaller than the stride, and windows that end at the top address, run correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle or done |
| addr_lo | input | AW | First address of the test window |
| addr_hi | input | AW | Last address of the test window (inclusive, not below addr_lo) |
| reps | input | RW | Number of inverse passes per offset, 0 treated as 1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| ram_en | output | 1 | RAM access request |
| ram_we | output | 1 | Write when high, read when low |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid one cycle after the read request |
| err_valid | output | 1 | One-cycle mismatch strobe |
| err_addr | output | AW | Address of the failing read |
| err_exp | output | DW | Pattern word that was expected |
| err_got | output | DW | Word that was returned |

## Verification
Every RAM request belongs to the cycle in which it is presented. The bench samples it at the falling edge of that cycle, using a cycle index counted from the edge that accepted `start`, and compares it with the request that the index implies for the current pattern, offset, sweep and address. A mismatch strobe is due two edges after its read: one edge for the RAM latency and one for the registered comparison. So the bench keeps a two-deep queue of expected strobes, built from its own memory model with injected stuck-bit and neighbour-coupling faults, and checks each strobe's fields exactly two cycles after the read. The end of the run is checked against the closed-form edge count of R7. Runs that carry a stray `start` or a changed repeat count mid-run must reach `done` on exactly that same edge.

// File: rtl/stride_bist_pkg.sv
package stride_bist_pkg;

    // Sweep phase of the test engine
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_WSTR  = 3'd1,   // pattern into stride cells
        PH_WINV  = 3'd2,   // inverse into all other cells
        PH_READ  = 3'd3,   // read back stride cells
        PH_DRAIN = 3'd4,   // last read data returning
        PH_DONE  = 3'd5
    } phase_e;

endpackage

// File: rtl/stride_bist_walker.sv
// Address sweep with a modulo counter running alongside it.
module stride_bist_walker #(
    parameter int AW     = 10,
    parameter int STRIDE = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step,
    input  logic [AW-1:0]        base,
    input  logic [AW-1:0]        top,
    output logic [AW-1:0]        addr,
    output logic [$clog2(STRIDE)-1:0] modc,
    output logic                 last
);
    localparam int MW = $clog2(STRIDE);
    localparam logic [MW-1:0] MOD_LAST = MW'(STRIDE - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [MW-1:0] modc;
    } walk_s;

    walk_s walk_q, walk_d;

    always_comb begin
        walk_d = walk_q;
        if (clear) begin
            walk_d.addr = base;
            walk_d.modc = '0;
        end else if (step) begin
            if (walk_q.addr == top) begin
                walk_d.addr = base;
                walk_d.modc = '0;
            end else begin
                walk_d.addr = walk_q.addr + 1'b1;
                walk_d.modc = (walk_q.modc == MOD_LAST) ? '0 : walk_q.modc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign addr = walk_q.addr;
    assign modc = walk_q.modc;
    assign last = (walk_q.addr == top);

endmodule

// File: rtl/stride_bist_ctrl.sv
// Phase, offset, pattern and repeat sequencing; RAM request generation.
module stride_bist_ctrl
    import stride_bist_pkg::*;
#(
    parameter int AW     = 10,
    parameter int DW     = 32,
    parameter int RW     = 4,
    parameter int STRIDE = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [AW-1:0]             lo_in,
    input  logic [AW-1:0]             hi_in,
    input  logic [RW-1:0]             reps_in,
    input  logic                      walk_last,
    input  logic [$clog2(STRIDE)-1:0] walk_modc,
    input  logic [AW-1:0]             walk_addr,
    output logic                      walk_clear,
    output logic                      walk_step,
    output logic [AW-1:0]             walk_base,
    output logic [AW-1:0]             walk_top,
    output logic                      busy,
    output logic                      done,
    output logic                      ram_en,
    output logic                      ram_we,
    output logic [AW-1:0]             ram_addr,
    output logic [DW-1:0]             ram_wdata,
    output logic                      rd_issue,
    output logic [DW-1:0]             rd_exp
);
    localparam int MW = $clog2(STRIDE);
    localparam logic [MW-1:0] OFF_LAST = MW'(STRIDE - 1);

    typedef struct packed {
        phase_e        phase;
        logic [MW-1:0] off;
        logic          pat;
        logic [RW-1:0] rep;
        logic [RW-1:0] reps;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
    } ctrl_s;

    ctrl_s ctl_q, ctl_d;

    logic          on_stride;
    logic [DW-1:0] pat_word;

    assign on_stride = (walk_modc == ctl_q.off);
    assign pat_word  = {DW{ctl_q.pat}};

    always_comb begin
        ctl_d      = ctl_q;
        walk_clear = 1'b0;
        walk_step  = 1'b0;
        case (ctl_q.phase)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    ctl_d.phase = PH_WSTR;
                    ctl_d.off   = '0;
                    ctl_d.pat   = 1'b0;
                    ctl_d.rep   = RW'(1);
                    ctl_d.reps  = (reps_in == '0) ? RW'(1) : reps_in;
                    ctl_d.lo    = lo_in;
                    ctl_d.hi    = hi_in;
                    walk_clear  = 1'b1;
                end
            end
            PH_WSTR: begin
                walk_step = 1'b1;
                if (walk_last) begin
                    ctl_d.phase = PH_WINV;
                    ctl_d.rep   = RW'(1);
                end
            end
            PH_WINV: begin
                walk_step = 1'b1;
                if (walk_last) begin
                    if (ctl_q.rep == ctl_q.reps) ctl_d.phase = PH_READ;
                    else                         ctl_d.rep   = ctl_q.rep + 1'b1;
                end
            end
            PH_READ: begin
                walk_step = 1'b1;
                if (walk_last) begin
                    if (ctl_q.off == OFF_LAST) begin
                        ctl_d.off = '0;
                        if (ctl_q.pat) begin
                            ctl_d.phase = PH_DRAIN;
                        end else begin
                            ctl_d.pat   = 1'b1;
                            ctl_d.phase = PH_WSTR;
                        end
                    end else begin
                        ctl_d.off   = ctl_q.off + 1'b1;
                        ctl_d.phase = PH_WSTR;
                    end
                end
            end
            PH_DRAIN: ctl_d.phase = PH_DONE;
            default:  ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // RAM request for the current sweep cycle
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_wdata = '0;
        case (ctl_q.phase)
            PH_WSTR: begin
                ram_en    = on_stride;
                ram_we    = 1'b1;
                ram_wdata = pat_word;
            end
            PH_WINV: begin
                ram_en    = !on_stride;
                ram_we    = 1'b1;
                ram_wdata = ~pat_word;
            end
            PH_READ: begin
                ram_en = on_stride;
            end
            default: ;
        endcase
    end

    assign ram_addr  = walk_addr;
    assign rd_issue  = ram_en && !ram_we;
    assign rd_exp    = pat_word;
    assign walk_base = ctl_d.lo;
    assign walk_top  = ctl_q.hi;
    assign busy      = (ctl_q.phase == PH_WSTR) || (ctl_q.phase == PH_WINV) ||
                       (ctl_q.phase == PH_READ) || (ctl_q.phase == PH_DRAIN);
    assign done      = (ctl_q.phase == PH_DONE);

endmodule

// File: rtl/stride_bist_check.sv
// Aligns the expected word with the one-cycle RAM latency and compares.
module stride_bist_check #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_exp,
    input  logic [DW-1:0] rdata,
    output logic          err_valid,
    output logic [AW-1:0] err_addr,
    output logic [DW-1:0] err_exp,
    output logic [DW-1:0] err_got
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] paddr;
        logic [DW-1:0] pexp;
        logic          ev;
        logic [AW-1:0] ea;
        logic [DW-1:0] ee;
        logic [DW-1:0] eg;
    } chk_s;

    chk_s chk_q, chk_d;

    always_comb begin
        chk_d       = chk_q;
        chk_d.pend  = rd_issue;
        chk_d.paddr = rd_addr;
        chk_d.pexp  = rd_exp;
        chk_d.ev    = chk_q.pend && (rdata != chk_q.pexp);
        if (chk_q.pend && (rdata != chk_q.pexp)) begin
            chk_d.ea = chk_q.paddr;
            chk_d.ee = chk_q.pexp;
            chk_d.eg = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign err_valid = chk_q.ev;
    assign err_addr  = chk_q.ea;
    assign err_exp   = chk_q.ee;
    assign err_got   = chk_q.eg;

endmodule

// File: rtl/stride_bist.sv
module stride_bist #(
    parameter int AW     = 10,
    parameter int DW     = 32,
    parameter int RW     = 4,
    parameter int STRIDE = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_lo,
    input  logic [AW-1:0] addr_hi,
    input  logic [RW-1:0] reps,
    output logic          busy,
    output logic          done,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          err_valid,
    output logic [AW-1:0] err_addr,
    output logic [DW-1:0] err_exp,
    output logic [DW-1:0] err_got
);
    localparam int MW = $clog2(STRIDE);

    logic          walk_clear, walk_step, walk_last;
    logic [AW-1:0] walk_base, walk_top, walk_addr;
    logic [MW-1:0] walk_modc;
    logic          rd_issue;
    logic [DW-1:0] rd_exp;

    stride_bist_walker #(.AW(AW), .STRIDE(STRIDE)) walker_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (walk_clear),
        .step  (walk_step),
        .base  (walk_base),
        .top   (walk_top),
        .addr  (walk_addr),
        .modc  (walk_modc),
        .last  (walk_last)
    );

    stride_bist_ctrl #(.AW(AW), .DW(DW), .RW(RW), .STRIDE(STRIDE)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .lo_in      (addr_lo),
        .hi_in      (addr_hi),
        .reps_in    (reps),
        .walk_last  (walk_last),
        .walk_modc  (walk_modc),
        .walk_addr  (walk_addr),
        .walk_clear (walk_clear),
        .walk_step  (walk_step),
        .walk_base  (walk_base),
        .walk_top   (walk_top),
        .busy       (busy),
        .done       (done),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .rd_issue   (rd_issue),
        .rd_exp     (rd_exp)
    );

    stride_bist_check #(.AW(AW), .DW(DW)) check_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issue  (rd_issue),
        .rd_addr   (walk_addr),
        .rd_exp    (rd_exp),
        .rdata     (ram_rdata),
        .err_valid (err_valid),
        .err_addr  (err_addr),
        .err_exp   (err_exp),
        .err_got   (err_got)
    );

endmodule

// File: rtl/stride_bist_sva.sv
module stride_bist_sva #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] addr_lo,
    input logic [AW-1:0] addr_hi,
    input logic          busy,
    input logic          done,
    input logic          ram_en,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic          err_valid
);

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !ram_en); // R3
    AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) err_valid |-> $past(ram_en && !ram_we, 2)); // R8
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) err_valid |=> !err_valid); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done); // R9
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && busy)); // R9
    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) ram_en |-> (ram_addr >= addr_lo && ram_addr <= addr_hi)); // R10

endmodule

bind stride_bist stride_bist_sva #(.AW(AW)) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .addr_lo   (addr_lo),
    .addr_hi   (addr_hi),
    .busy      (busy),
    .done      (done),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .err_valid (err_valid)
);

// File: tb/stride_bist_tb_top.sv
`timescale 1ns/1ps
module stride_bist_tb_top;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int RW = 4;
    localparam int NOFF = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] addr_lo, addr_hi;
    logic [RW-1:0] reps;
    logic          busy, done, ram_en, ram_we, err_valid;
    logic [AW-1:0] ram_addr, err_addr;
    logic [DW-1:0] ram_wdata, ram_rdata, err_exp, err_got;

    always #2 clk = ~clk;

    stride_bist dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .reps(reps), .busy(busy), .done(done), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .err_valid(err_valid), .err_addr(err_addr), .err_exp(err_exp), .err_got(err_got)
    );

    // RAM model with optional stuck-at-1 bit and neighbour coupling fault
    logic [DW-1:0] mem [2**AW];
    logic          stk_on = 1'b0;
    logic [AW-1:0] stk_addr = '0;
    logic [DW-1:0] stk_mask = '0;
    logic          cpl_on = 1'b0;
    logic [AW-1:0] cpl_aggr = '0;

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        return mem[a] | ((stk_on && a == stk_addr) ? stk_mask : '0);
    endfunction

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                mem[ram_addr] <= ram_wdata;
                if (cpl_on && ram_addr == cpl_aggr) mem[cpl_aggr + 1'b1] <= ram_wdata;
            end else begin
                ram_rdata <= model_read(ram_addr);
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Expected RAM request in cycle t of a run (cls: 3,4,5 sweep kind, 7 after end)
    function automatic void model_op(input int t, input int n, input int r, input int lo,
                                     output bit en, output bit we, output int a,
                                     output logic [DW-1:0] wd, output int cls);
        int per_off, per_pat, pat, rem, off, ph, i;
        logic [DW-1:0] pw;
        per_off = (2 + r) * n;
        per_pat = NOFF * per_off;
        en = 0; we = 0; a = 0; wd = '0; cls = 7;
        if (t >= 2 * per_pat) return;
        pat = t / per_pat;
        rem = t % per_pat;
        off = rem / per_off;
        ph  = (rem % per_off) / n;
        i   = (rem % per_off) % n;
        pw  = (pat != 0) ? '1 : '0;
        a   = lo + i;
        if (ph == 0) begin
            cls = 3; en = ((i % NOFF) == off); we = 1; wd = pw;
        end else if (ph <= r) begin
            cls = 4; en = ((i % NOFF) != off); we = 1; wd = ~pw;
        end else begin
            cls = 5; en = ((i % NOFF) == off); we = 0; wd = pw;
        end
    endfunction

    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [DW-1:0] e;
        logic [DW-1:0] g;
    } eexp_t;

    task automatic run_case(input int lo, input int hi, input int rin,
                            input int fmode, input bit disturb);
        int n, r, tot, done_t, bad3, bad4, bad5, bad7, bad10, bad8, seen, expn;
        eexp_t s1, s2;
        bit en, we;
        int a, cls;
        logic [DW-1:0] wd;
        n = hi - lo + 1;
        r = (rin == 0) ? 1 : rin;
        tot = 2 * NOFF * (2 + r) * n;
        done_t = -1;
        bad3 = 0; bad4 = 0; bad5 = 0; bad7 = 0; bad10 = 0; bad8 = 0; seen = 0; expn = 0;
        s1 = '0; s2 = '0;
        stk_on = 0; cpl_on = 0;
        if (fmode == 1) begin
            stk_on = 1;
            stk_addr = AW'(lo + int'($urandom % n));
            stk_mask = DW'(1) << ($urandom % DW);
        end else if (fmode == 2) begin
            cpl_on = 1;
            cpl_aggr = AW'(lo + int'($urandom % (n - 1)));
        end
        @(negedge clk);
        addr_lo = AW'(lo); addr_hi = AW'(hi); reps = RW'(rin); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < tot + 8; t++) begin
            if (t > 0) @(negedge clk);
            if (disturb && t == tot / 2) begin start = 1'b1; reps = RW'(rin) ^ 4'h5; end
            if (disturb && t == tot / 2 + 1) begin start = 1'b0; reps = RW'(rin); end
            model_op(t, n, r, lo, en, we, a, wd, cls);
            if (ram_en !== en || (en && (ram_we !== we || ram_addr !== AW'(a) ||
                                         (we && ram_wdata !== wd)))) begin
                if (cls == 3) bad3++;
                else if (cls == 4) bad4++;
                else if (cls == 5) bad5++;
                else bad7++;
            end
            if (ram_en && (int'(ram_addr) < lo || int'(ram_addr) > hi)) bad10++;
            // strobe due this cycle
            if (s2.v) begin
                if (!(err_valid === 1'b1 && err_addr == s2.a && err_exp == s2.e && err_got == s2.g))
                    bad8++;
            end else if (err_valid !== 1'b0) bad8++;
            if (err_valid === 1'b1) seen++;
            s2 = s1;
            s1 = '0;
            if (en && !we) begin
                s1.a = AW'(a);
                s1.e = wd;
                s1.g = model_read(AW'(a));
                s1.v = (s1.g != s1.e);
                if (s1.v) expn++;
            end
            if (done === 1'b1) begin done_t = t; break; end
        end
        chk(done_t == tot + 1, disturb ? "R2" : ((rin == 0) ? "R6" : "R7"),
            "cycles to done", done_t, tot + 1);
        chk(bad3 == 0, "R3", "stride write sweep mismatching cycles", bad3, 0);
        chk(bad4 == 0, "R4", "inverse sweep mismatching cycles", bad4, 0);
        chk(bad5 == 0, "R5", "read sweep mismatching cycles", bad5, 0);
        chk(bad7 == 0, "R7", "accesses after last read", bad7, 0);
        chk(bad10 == 0, "R10", "accesses outside window", bad10, 0);
        chk(bad8 == 0, "R8", "error strobe mismatching cycles", bad8, 0);
        chk(seen == expn, "R8", "error strobe count", seen, expn);
        if (fmode != 0) chk(seen > 0, "R8", "fault produced strobes", seen, 1);
        repeat (4) @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0 && ram_en === 1'b0, "R9", "done held, idle",
            {done, busy, ram_en}, 3'b100);
        stk_on = 0; cpl_on = 0;
    endtask

    initial begin
        int lo, n;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; start = 1'b0; addr_lo = '0; addr_hi = '0; reps = '0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && err_valid === 1'b0 && ram_en === 1'b0,
            "R1", "outputs in reset", {busy, done, err_valid, ram_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed: clean run from window base 0
        run_case(0, 39, 1, 0, 1'b0);
        // random window, stuck-at-1 bit
        lo = 100 + int'($urandom % 200);
        n  = 21 + int'($urandom % 25);
        run_case(lo, lo + n - 1, 2, 1, 1'b0);
        // repeat count zero, coupling fault
        run_case(300, 329, 0, 2, 1'b0);
        // window at top of address space, stray start and reps change mid-run
        run_case(1000, 1023, 3, 0, 1'b1);
        // window smaller than the stride
        lo = int'($urandom % 900);
        run_case(lo, lo + 6, 1 + int'($urandom % 15), 0, 1'b0);
        // random everything
        lo = int'($urandom % 900);
        n  = 20 + int'($urandom % 21);
        run_case(lo, lo + n - 1, 1 + int'($urandom % 4), int'($urandom % 3), 1'b0);
        summary();
        $finish;
    end

endmodule